// File: doc/BRIEF.md
# Byte Load Decode and Execute Unit

This unit takes one 32-bit instruction word at a time for a 64-bit RISC core and carries out a family of four zero-extending single-byte loads. Two forms take the byte offset from a signed 16-bit displacement and two take it from an index register. One form of each pair also writes the computed address back into its base register. Bit 0 of the instruction is its most significant bit, so bit `n` of the word is `insn_i[31-n]`.

The unit holds its own 32 x 64-bit register file. The base and index values are read from it, and the results are written back into it. A test write port loads the file and a test read port observes it, so a bench or a debug path can set up and inspect state. For each accepted load the unit issues one byte read on a request/response memory handshake. It then writes the destination register and, for an update form, the base register. Last it pulses `done_o` and advances an internal program counter by 4. Any word outside the four encodings gives a one-cycle illegal pulse and changes nothing.

Top module: `byte_load_unit`

## Requirements
- R1: While `rst_ni` is low and after it is released, `ready_o` is 1, `mem_req_o`, `done_o` and `illegal_o` are 0, `pc_o` is 0 and every register reads 0.
- R2: Decode uses opcode `insn_i[31:26]`, destination `insn_i[25:21]`, base `insn_i[20:16]`, displacement `insn_i[15:0]`, index `insn_i[15:11]` and extended opcode `insn_i[10:1]`. Opcode 34 is the displacement load and 35 the displacement load with update. Opcode 31 with extended opcode 87 is the indexed load, and with 119 the indexed load with update. `insn_i[0]` is ignored.
- R3: A displacement form addresses the base value plus the sign-extended displacement. The sum is taken modulo 2^64, and its low 32 bits appear on `mem_addr_o`.
- R4: An indexed form addresses the base value plus the index register contents. The sum is taken modulo 2^64, and its low 32 bits appear on `mem_addr_o`.
- R5: In a form without update, a base field of 0 makes the base value 0, whatever register 0 holds.
- R6: An update form always uses the contents of the named base register, register 0 included. After the load it writes the 32-bit address, zero-extended to 64 bits, into that register.
- R7: The destination register receives the returned byte in bits 7:0 and zeros in bits 63:8.
- R8: In an update form whose base and destination fields are equal, that register ends up holding the zero-extended address.
- R9: A word that matches none of the four encodings sets `illegal_o` for exactly the cycle after it is accepted. It issues no memory request, writes no register, leaves `pc_o` unchanged and leaves `ready_o` at 1.
- R10: `ready_o` is 0 from the accepting edge of a legal load until the unit returns to idle. `mem_req_o` stays 1 with `mem_addr_o` stable until `mem_rvalid_i` is sampled high.
- R11: Each legal load ends with `done_o` high for one cycle, and `pc_o` increases by 4 on the next edge. `pc_o` changes at no other time.
- R12: While `ready_o` is 1, `tw_en_i` writes `tw_data_i` into register `tw_idx_i`. `tr_data_o` shows register `tr_idx_i` without delay.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_valid_i | input | 1 | Instruction word valid; accepted when ready_o is 1 |
| insn_i | input | 32 | Instruction word, bit 0 = MSB |
| ready_o | output | 1 | Unit idle and able to accept a word |
| illegal_o | output | 1 | One-cycle pulse for an unrecognised word |
| done_o | output | 1 | One-cycle pulse when a load completes |
| pc_o | output | 32 | Internal program counter |
| mem_req_o | output | 1 | Byte read request, held until response |
| mem_addr_o | output | 32 | Byte address of the request |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 8 | Returned byte |
| tw_en_i | input | 1 | Test write enable |
| tw_idx_i | input | 5 | Test write register index |
| tw_data_i | input | 64 | Test write data |
| tr_idx_i | input | 5 | Test read register index |
| tr_data_o | output | 64 | Test read data |

## Verification
The bench runs every form against a base field of 0, against ordinary base registers, and against a base equal to the destination. It combines these with displacements 0, +1, -1, +32767 and -32768, or with several index registers. The literal-zero rule is told apart from the real register 0 because register 0 holds a nonzero value. Bases near 2^64 and bases with nonzero upper halves show whether the 64-bit wrap and the 32-bit truncation are done. A base equal to the destination shows the order of the two register writes. Words with neighbouring opcodes and extended opcodes, varying memory latency and a set low bit show which words are decoded and that the request is held until the response arrives.

// File: rtl/bl_pkg.sv
package bl_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned FLD_W  = 5;
  localparam int unsigned DISP_W = 16;
  localparam int unsigned BYTE_W = 8;

  localparam logic [5:0] OPC_DISP     = 6'd34;
  localparam logic [5:0] OPC_DISP_UPD = 6'd35;
  localparam logic [5:0] OPC_EXT      = 6'd31;
  localparam logic [9:0] XO_IDX       = 10'd87;
  localparam logic [9:0] XO_IDX_UPD   = 10'd119;

  typedef struct packed {
    logic              legal;
    logic              upd;
    logic              idx;
    logic              zero_base;
    logic [FLD_W-1:0]  rd;
    logic [FLD_W-1:0]  ra;
    logic [FLD_W-1:0]  rb;
    logic [DISP_W-1:0] disp;
  } dec_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_MEM   = 3'd1,
    ST_WB_RD = 3'd2,
    ST_WB_RA = 3'd3,
    ST_DONE  = 3'd4
  } st_e;
endpackage

// File: rtl/bl_decode.sv
module bl_decode
  import bl_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output dec_t              dec_o
);
  logic [5:0] opc;
  logic [9:0] xo;
  logic       d_form, x_form, unused_rc;

  assign opc       = insn_i[31:26];
  assign xo        = insn_i[10:1];
  assign unused_rc = insn_i[0];

  always_comb begin
    d_form = (opc == OPC_DISP) || (opc == OPC_DISP_UPD);
    x_form = (opc == OPC_EXT) && ((xo == XO_IDX) || (xo == XO_IDX_UPD));
    dec_o.legal     = d_form || x_form;
    dec_o.upd       = (opc == OPC_DISP_UPD) || (x_form && (xo == XO_IDX_UPD));
    dec_o.idx       = x_form;
    dec_o.rd        = insn_i[25:21];
    dec_o.ra        = insn_i[20:16];
    dec_o.rb        = insn_i[15:11];
    dec_o.disp      = insn_i[15:0];
    dec_o.zero_base = !dec_o.upd && (dec_o.ra == '0);
  end
endmodule

// File: rtl/bl_regfile.sv
module bl_regfile #(
  parameter int unsigned NREG = 32,
  parameter int unsigned XLEN = 64,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [IW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [IW-1:0]   raddr_a_i,
  output logic [XLEN-1:0] rdata_a_o,
  input  logic [IW-1:0]   raddr_b_i,
  output logic [XLEN-1:0] rdata_b_o,
  input  logic [IW-1:0]   raddr_t_i,
  output logic [XLEN-1:0] rdata_t_o
);
  logic [XLEN-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [XLEN-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              q <= '0;
      else if (we_i && (waddr_i == IW'(g)))     q <= wdata_i;
    end
    assign regs[g] = q;
  end

  assign rdata_a_o = regs[raddr_a_i];
  assign rdata_b_o = regs[raddr_b_i];
  assign rdata_t_o = regs[raddr_t_i];
endmodule

// File: rtl/bl_agen.sv
module bl_agen #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned AW     = 32,
  parameter int unsigned DISP_W = 16
) (
  input  logic [XLEN-1:0]   base_i,
  input  logic [XLEN-1:0]   index_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              use_idx_i,
  input  logic              zero_base_i,
  output logic [AW-1:0]     ea_o
);
  logic [XLEN-1:0] base, offs, full_sum;
  logic [XLEN-AW-1:0] unused_hi;

  always_comb begin
    base     = zero_base_i ? '0 : base_i;
    offs     = use_idx_i ? index_i : {{(XLEN-DISP_W){disp_i[DISP_W-1]}}, disp_i};
    full_sum = base + offs;
  end

  assign ea_o      = full_sum[AW-1:0];
  assign unused_hi = full_sum[XLEN-1:AW];
endmodule

// File: rtl/byte_load_unit.sv
module byte_load_unit
  import bl_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned AW   = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              insn_valid_i,
  input  logic [INSN_W-1:0] insn_i,
  output logic              ready_o,
  output logic              illegal_o,
  output logic              done_o,
  output logic [AW-1:0]     pc_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  input  logic              tw_en_i,
  input  logic [IW-1:0]     tw_idx_i,
  input  logic [XLEN-1:0]   tw_data_i,
  input  logic [IW-1:0]     tr_idx_i,
  output logic [XLEN-1:0]   tr_data_o
);
  dec_t              dec;
  st_e               st_q;
  logic [AW-1:0]     ea, ea_q, pc_q;
  logic [IW-1:0]     rd_q, ra_q;
  logic              upd_q, illegal_q;
  logic [BYTE_W-1:0] byte_q;
  logic [XLEN-1:0]   base_val, index_val;
  logic              we;
  logic [IW-1:0]     waddr;
  logic [XLEN-1:0]   wdata;
  logic              accept;

  bl_decode u_decode (.insn_i(insn_i), .dec_o(dec));

  bl_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we),
    .waddr_i   (waddr),
    .wdata_i   (wdata),
    .raddr_a_i (IW'(dec.ra)),
    .rdata_a_o (base_val),
    .raddr_b_i (IW'(dec.rb)),
    .rdata_b_o (index_val),
    .raddr_t_i (tr_idx_i),
    .rdata_t_o (tr_data_o)
  );

  bl_agen #(.XLEN(XLEN), .AW(AW), .DISP_W(DISP_W)) u_agen (
    .base_i      (base_val),
    .index_i     (index_val),
    .disp_i      (dec.disp),
    .use_idx_i   (dec.idx),
    .zero_base_i (dec.zero_base),
    .ea_o        (ea)
  );

  assign accept = insn_valid_i && (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ea_q      <= '0;
      rd_q      <= '0;
      ra_q      <= '0;
      upd_q     <= 1'b0;
      byte_q    <= '0;
      illegal_q <= 1'b0;
      pc_q      <= '0;
    end else begin
      illegal_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          if (dec.legal) begin
            ea_q  <= ea;
            rd_q  <= IW'(dec.rd);
            ra_q  <= IW'(dec.ra);
            upd_q <= dec.upd;
            st_q  <= ST_MEM;
          end else begin
            illegal_q <= 1'b1;
          end
        end
        ST_MEM: if (mem_rvalid_i) begin
          byte_q <= mem_rdata_i;
          st_q   <= ST_WB_RD;
        end
        // destination first, base last: base wins when the fields coincide
        ST_WB_RD: st_q <= upd_q ? ST_WB_RA : ST_DONE;
        ST_WB_RA: st_q <= ST_DONE;
        ST_DONE: begin
          pc_q <= pc_q + AW'(4);
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    we    = tw_en_i && (st_q == ST_IDLE);
    waddr = tw_idx_i;
    wdata = tw_data_i;
    if (st_q == ST_WB_RD) begin
      we    = 1'b1;
      waddr = rd_q;
      wdata = {{(XLEN-BYTE_W){1'b0}}, byte_q};
    end else if (st_q == ST_WB_RA) begin
      we    = 1'b1;
      waddr = ra_q;
      wdata = {{(XLEN-AW){1'b0}}, ea_q};
    end
  end

  assign ready_o    = (st_q == ST_IDLE);
  assign done_o     = (st_q == ST_DONE);
  assign mem_req_o  = (st_q == ST_MEM);
  assign mem_addr_o = ea_q;
  assign illegal_o  = illegal_q;
  assign pc_o       = pc_q;
endmodule

// File: rtl/bl_chk.sv
module bl_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ready_o,
  input logic          illegal_o,
  input logic          done_o,
  input logic [AW-1:0] pc_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rvalid_i
);
  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R10
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !ready_o);

  // R10
  ready_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(done_o));

  // R11
  done_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && (pc_o == $past(pc_o) + AW'(4))));

  // R11
  pc_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(pc_o));

  // R9
  illegal_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (ready_o && !mem_req_o && !done_o));
endmodule

bind byte_load_unit bl_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ready_o      (ready_o),
  .illegal_o    (illegal_o),
  .done_o       (done_o),
  .pc_o         (pc_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i)
);

// File: tb/byte_load_unit_tb.sv
`timescale 1ns/1ps
module byte_load_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [31:0] insn = '0;
  logic        ready, illegal, done, mem_req;
  logic [31:0] pc, mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        tw_en = 1'b0;
  logic [4:0]  tw_idx = '0;
  logic [63:0] tw_data = '0;
  logic [4:0]  tr_idx = '0;
  logic [63:0] tr_data;

  int n_chk = 0;
  int n_err = 0;
  logic [63:0] model [32];

  always #2 clk = ~clk;

  byte_load_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .insn_valid_i(insn_valid), .insn_i(insn),
    .ready_o(ready), .illegal_o(illegal), .done_o(done), .pc_o(pc),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .tw_en_i(tw_en), .tw_idx_i(tw_idx),
    .tw_data_i(tw_data), .tr_idx_i(tr_idx), .tr_data_o(tr_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ a[23:16] ^ {a[31:28], a[11:8]} ^ 8'hA5;
  endfunction

  task automatic get_reg(input int idx, output logic [63:0] v);
    tr_idx = 5'(idx);
    #0.5;
    v = tr_data;
  endtask

  task automatic put_reg(input int idx, input logic [63:0] v);
    @(negedge clk);
    tw_en = 1'b1; tw_idx = 5'(idx); tw_data = v;
    @(negedge clk);
    tw_en = 1'b0;
    model[idx] = v;
  endtask

  // form: 0 disp, 1 disp+upd, 2 idx, 3 idx+upd
  task automatic exec(input int form, input int rd, input int ra, input int rb,
                      input logic [15:0] disp, input int lat, input logic rc);
    logic [31:0] w, ea, pc0;
    logic [63:0] base, offs, sum, v;
    logic upd, useidx, zb, seen;
    string atag;
    upd    = (form == 1) || (form == 3);
    useidx = (form >= 2);
    zb     = !upd && (ra == 0);
    case (form)
      0: w = {6'd34, 5'(rd), 5'(ra), disp};
      1: w = {6'd35, 5'(rd), 5'(ra), disp};
      2: w = {6'd31, 5'(rd), 5'(ra), 5'(rb), 10'd87, rc};
      default: w = {6'd31, 5'(rd), 5'(ra), 5'(rb), 10'd119, rc};
    endcase
    base = zb ? 64'd0 : model[ra];
    offs = useidx ? model[rb] : {{48{disp[15]}}, disp};
    sum  = base + offs;
    ea   = sum[31:0];
    atag = zb ? "R5" : (upd ? "R6" : (useidx ? "R4" : "R3"));
    if (rc) atag = "R2";
    pc0 = pc;
    @(negedge clk);
    insn_valid = 1'b1; insn = w;
    @(negedge clk);
    insn_valid = 1'b0;
    chk("R10 ready low", 64'(ready), 64'd0);
    chk("R10 req", 64'(mem_req), 64'd1);
    chk({atag, " address"}, 64'(mem_addr), 64'(ea));
    for (int i = 0; i < lat; i++) @(negedge clk);
    if (lat > 0) begin
      chk("R10 req held", 64'(mem_req), 64'd1);
      chk("R10 addr stable", 64'(mem_addr), 64'(ea));
    end
    mem_rvalid = 1'b1; mem_rdata = mem_byte(ea);
    @(negedge clk);
    mem_rvalid = 1'b0; mem_rdata = '0;
    seen = 1'b0;
    for (int i = 0; i < 8 && !seen; i++) begin
      if (done) seen = 1'b1;
      else begin
        chk("R10 busy", 64'(ready), 64'd0);
        @(negedge clk);
      end
    end
    chk("R11 done", 64'(seen), 64'd1);
    @(negedge clk);
    chk("R11 pc", 64'(pc), 64'(pc0 + 32'd4));
    chk("R11 done pulse", 64'(done), 64'd0);
    chk("R10 ready back", 64'(ready), 64'd1);
    model[rd] = {56'd0, mem_byte(ea)};
    if (upd) model[ra] = {32'd0, ea};
    get_reg(rd, v);
    chk((upd && ra == rd) ? "R8 rd=ra" : "R7 dest", v, model[rd]);
    get_reg(ra, v);
    chk(upd ? "R6 base wb" : "R5 base kept", v, model[ra]);
  endtask

  task automatic bad(input logic [31:0] w);
    logic [63:0] v0, v1, v;
    logic [31:0] pc0;
    pc0 = pc;
    get_reg(int'(w[25:21]), v0);
    get_reg(int'(w[20:16]), v1);
    @(negedge clk);
    insn_valid = 1'b1; insn = w;
    @(negedge clk);
    insn_valid = 1'b0;
    chk("R9 illegal pulse", 64'(illegal), 64'd1);
    chk("R9 ready", 64'(ready), 64'd1);
    chk("R9 no req", 64'(mem_req), 64'd0);
    @(negedge clk);
    chk("R9 pulse width", 64'(illegal), 64'd0);
    chk("R9 pc", 64'(pc), 64'(pc0));
    get_reg(int'(w[25:21]), v);
    chk("R9 rd untouched", v, v0);
    get_reg(int'(w[20:16]), v);
    chk("R9 ra untouched", v, v1);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] v;
    int dsel, rd, rb;
    logic [15:0] dl [5];
    int rbl [5];
    int ral [3];
    dl[0] = 16'h0000; dl[1] = 16'h0001; dl[2] = 16'hFFFF; dl[3] = 16'h7FFF; dl[4] = 16'h8000;
    rbl[0] = 0; rbl[1] = 2; rbl[2] = 9; rbl[3] = 3; rbl[4] = 12;
    ral[0] = 0; ral[1] = 3; ral[2] = 12;
    #1;
    chk("R1 ready in reset", 64'(ready), 64'd1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", 64'(ready), 64'd1);
    chk("R1 req", 64'(mem_req), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 illegal", 64'(illegal), 64'd0);
    chk("R1 pc", 64'(pc), 64'd0);
    for (int i = 0; i < 32; i++) begin
      get_reg(i, v);
      chk("R1 reg zero", v, 64'd0);
    end
    for (int i = 0; i < 32; i++)
      put_reg(i, 64'h0101_0101_0101_0101 * 64'(i) + 64'h40);
    put_reg(0, 64'h0000_0000_0000_1000);
    put_reg(2, 64'h0000_0000_0000_0010);
    put_reg(3, 64'hFFFF_FFFF_FFFF_FFF8);
    put_reg(9, 64'hFFFF_FFFF_0000_0100);
    put_reg(12, 64'hABCD_0000_8000_0010);
    for (int i = 0; i < 32; i++) begin
      get_reg(i, v);
      chk("R12 test port", v, model[i]);
    end

    for (int f = 0; f < 4; f++)
      for (int a = 0; a < 3; a++)
        for (int s = 0; s < 5; s++) begin
          dsel = s;
          rd = (s == 4) ? ral[a] : 20 + s;
          rb = rbl[s];
          exec(f, rd, ral[a], rb, dl[dsel], s % 3, 1'b0);
        end

    put_reg(4, 64'h0000_0000_FFFF_FFFF);
    put_reg(5, 64'h0000_0000_0000_0001);
    exec(2, 6, 4, 5, 16'h0, 1, 1'b1);
    exec(3, 7, 4, 5, 16'h0, 0, 1'b1);
    exec(0, 8, 5, 0, 16'hFFFE, 2, 1'b0);

    bad({6'd33, 5'd20, 5'd3, 16'h0004});
    bad({6'd36, 5'd21, 5'd3, 16'h0004});
    bad({6'd31, 5'd22, 5'd3, 5'd2, 10'd88, 1'b0});
    bad({6'd31, 5'd23, 5'd3, 5'd2, 10'd118, 1'b1});
    bad({6'd31, 5'd24, 5'd3, 5'd2, 10'd55, 1'b0});
    bad(32'h0000_0000);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule